// File: doc/BRIEF.md
# Inline Pixel-Sum Statistics Monitor

This block sits on a grey-scale pixel stream right after the sensor capture logic. Every beat passes straight through to the downstream stage with data, flags and valid untouched, and the block's ready simply mirrors the downstream ready. While the frame streams by, the block adds up the grey value of every accepted pixel. It also measures the frame's width and height from the stream's own framing flags, so nothing about the sensor geometry has to be configured.

When the frame's final pixel is accepted, the block copies the sum, the width and the height into result registers and raises a level interrupt. Software reads the three values through a small word-addressed register port and divides the sum by width times height itself. The interrupt stays up until software writes a one to bit 0 of the status word. The result registers keep the previous frame's values while the next frame is being added up, so software has a whole frame time to collect them.

Top module: `pixsum_monitor`

## Requirements
- R1: m_valid, m_data, m_user and m_last always equal s_valid, s_data, s_user and s_last in the same cycle.
- R2: s_ready always equals m_ready. A beat is accepted in a cycle where s_valid and m_ready are both high.
- R3: A frame opens with an accepted beat that has s_user bit 0 (start of frame) set. It closes with an accepted beat that has s_user bit 1 (end of frame) set. The SUM register (address 0) then holds the 32-bit sum of the 8-bit values of all accepted beats from the opening beat through the closing beat.
- R4: The WIDTH register (address 1) holds the number of accepted beats from the opening beat through the first beat with s_last set, counting both ends.
- R5: The HEIGHT register (address 2) holds the number of accepted beats with s_last set within the frame.
- R6: The result registers change only when a frame closes. While a later frame is being accumulated, they keep the last closed frame's values.
- R7: irq is low right after the edge that accepts the closing beat and high after the following edge. It then stays high until a write to STATUS (address 3) with data bit 0 set. A write with bit 0 clear, or a write to any other address, leaves irq high.
- R8: When a frame's completion and a clearing STATUS write reach the interrupt logic in the same cycle, irq stays high.
- R9: Accepted beats that arrive outside a frame (before any start-of-frame beat, or after an end-of-frame beat and before the next start) are ignored. This holds even when they carry the end-of-frame flag.
- R10: After synchronous reset, irq is low and SUM, WIDTH, HEIGHT and STATUS read 0.
- R11: reg_rdata shows the register selected by reg_addr one cycle after the address is presented. STATUS bit 0 reads as irq. Unmapped addresses read 0.
- R12: A start-of-frame beat that arrives inside an open frame discards the partial frame and starts accumulating again from that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Upstream beat valid |
| s_ready | output | 1 | Upstream ready, mirrors m_ready |
| s_data | input | PIX_W | Upstream grey value |
| s_user | input | USER_W | Upstream flags: bit 0 start of frame, bit 1 end of frame |
| s_last | input | 1 | Upstream end-of-line flag |
| m_valid | output | 1 | Downstream beat valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | PIX_W | Downstream grey value |
| m_user | output | USER_W | Downstream flags |
| m_last | output | 1 | Downstream end-of-line flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Frame-complete interrupt, level |

## Verification
Two functions can collide on the interrupt flop: the completion pulse of a frame and a software clear of the previous interrupt. The bench provokes this by accepting an end-of-frame beat and then, on the very next cycle, writing 1 to STATUS bit 0, so that the clear meets the registered completion pulse. It judges the outcome by irq staying high across that edge and the one after it, and by SUM reading the new frame's total.

// File: rtl/pixsum_pkg.sv
`timescale 1ns/1ps
package pixsum_pkg;

  // Register word selectors on the register port
  typedef enum logic [1:0] {
    SEL_SUM  = 2'd0,
    SEL_WID  = 2'd1,
    SEL_HGT  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  // Flag positions inside the stream user field
  localparam int unsigned USER_SOF_BIT = 0;
  localparam int unsigned USER_EOF_BIT = 1;

  // Decoded framing markers of one beat
  typedef struct packed {
    logic sof;
    logic eol;
    logic eof;
  } frame_marks_t;

endpackage

// File: rtl/pixsum_pass.sv
`timescale 1ns/1ps
module pixsum_pass #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned USER_W = 2
) (
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PIX_W-1:0]  s_data,
  input  logic [USER_W-1:0] s_user,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [PIX_W-1:0]  m_data,
  output logic [USER_W-1:0] m_user,
  output logic              m_last,
  output logic              beat
);
  // Straight wires: no register stage, no change to any field
  assign m_valid = s_valid;
  assign m_data  = s_data;
  assign m_user  = s_user;
  assign m_last  = s_last;
  assign s_ready = m_ready;
  assign beat    = s_valid & m_ready;
endmodule

// File: rtl/pixsum_accum.sv
`timescale 1ns/1ps
module pixsum_accum #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned SUM_W = 32,
  parameter int unsigned DIM_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      beat,
  input  logic [PIX_W-1:0]          pix,
  input  pixsum_pkg::frame_marks_t  marks,
  output logic                      done,
  output logic [SUM_W-1:0]          res_sum,
  output logic [DIM_W-1:0]          res_wid,
  output logic [DIM_W-1:0]          res_hgt
);
  logic             in_frame;
  logic             wid_ok;
  logic [SUM_W-1:0] acc;
  logic [DIM_W-1:0] col;
  logic [DIM_W-1:0] wid;
  logic [DIM_W-1:0] hgt;

  logic             active;
  logic             base_ok;
  logic [SUM_W-1:0] base_acc;
  logic [DIM_W-1:0] base_col;
  logic [DIM_W-1:0] base_hgt;
  logic [SUM_W-1:0] nxt_acc;
  logic [DIM_W-1:0] line_w;
  logic [DIM_W-1:0] nxt_col;
  logic [DIM_W-1:0] nxt_wid;
  logic [DIM_W-1:0] nxt_hgt;

  always_comb begin
    active   = beat & (marks.sof | in_frame);
    // a start-of-frame beat begins from empty state
    base_ok  = marks.sof ? 1'b0 : wid_ok;
    base_acc = marks.sof ? '0 : acc;
    base_col = marks.sof ? '0 : col;
    base_hgt = marks.sof ? '0 : hgt;
    nxt_acc  = base_acc + SUM_W'(pix);
    line_w   = base_col + DIM_W'(1);
    nxt_col  = marks.eol ? '0 : line_w;
    nxt_wid  = base_ok ? wid : line_w;
    nxt_hgt  = base_hgt + DIM_W'(marks.eol);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      wid_ok   <= 1'b0;
      acc      <= '0;
      col      <= '0;
      wid      <= '0;
      hgt      <= '0;
      done     <= 1'b0;
      res_sum  <= '0;
      res_wid  <= '0;
      res_hgt  <= '0;
    end else begin
      done <= 1'b0;
      if (active) begin
        in_frame <= ~marks.eof;
        wid_ok   <= base_ok | marks.eol;
        acc      <= nxt_acc;
        col      <= nxt_col;
        wid      <= nxt_wid;
        hgt      <= nxt_hgt;
        if (marks.eof) begin
          done    <= 1'b1;
          res_sum <= nxt_acc;
          res_wid <= nxt_wid;
          res_hgt <= nxt_hgt;
        end
      end
    end
  end
endmodule

// File: rtl/pixsum_regs.sv
`timescale 1ns/1ps
module pixsum_regs #(
  parameter int unsigned SUM_W  = 32,
  parameter int unsigned DIM_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [SUM_W-1:0]  res_sum,
  input  logic [DIM_W-1:0]  res_wid,
  input  logic [DIM_W-1:0]  res_hgt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import pixsum_pkg::*;

  localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(SEL_SUM);
  localparam logic [ADDR_W-1:0] A_WID  = ADDR_W'(SEL_WID);
  localparam logic [ADDR_W-1:0] A_HGT  = ADDR_W'(SEL_HGT);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(SEL_STAT);

  logic clr;
  logic unused_wbits;

  assign clr          = reg_wr & (reg_addr == A_STAT) & reg_wdata[0];
  assign unused_wbits = ^reg_wdata[DATA_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      // completion wins over a clear in the same cycle
      irq <= done | (irq & ~clr);
      case (reg_addr)
        A_SUM:   reg_rdata <= DATA_W'(res_sum);
        A_WID:   reg_rdata <= DATA_W'(res_wid);
        A_HGT:   reg_rdata <= DATA_W'(res_hgt);
        A_STAT:  reg_rdata <= DATA_W'(irq);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pixsum_monitor.sv
`timescale 1ns/1ps
module pixsum_monitor #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned USER_W = 2,
  parameter int unsigned SUM_W  = 32,
  parameter int unsigned DIM_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PIX_W-1:0]  s_data,
  input  logic [USER_W-1:0] s_user,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [PIX_W-1:0]  m_data,
  output logic [USER_W-1:0] m_user,
  output logic              m_last,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import pixsum_pkg::*;

  logic             beat;
  logic             frame_done;
  frame_marks_t     marks;
  logic [SUM_W-1:0] res_sum;
  logic [DIM_W-1:0] res_wid;
  logic [DIM_W-1:0] res_hgt;

  assign marks.sof = s_user[USER_SOF_BIT];
  assign marks.eof = s_user[USER_EOF_BIT];
  assign marks.eol = s_last;

  pixsum_pass #(.PIX_W(PIX_W), .USER_W(USER_W)) i_pass (
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_user(s_user), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_user(m_user), .m_last(m_last), .beat(beat)
  );

  pixsum_accum #(.PIX_W(PIX_W), .SUM_W(SUM_W), .DIM_W(DIM_W)) i_accum (
    .clk(clk), .rst(rst), .beat(beat), .pix(s_data), .marks(marks),
    .done(frame_done), .res_sum(res_sum), .res_wid(res_wid),
    .res_hgt(res_hgt)
  );

  pixsum_regs #(.SUM_W(SUM_W), .DIM_W(DIM_W), .ADDR_W(ADDR_W),
                .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .done(frame_done), .res_sum(res_sum),
    .res_wid(res_wid), .res_hgt(res_hgt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );
endmodule

// File: rtl/pixsum_monitor_chk.sv
`timescale 1ns/1ps
module pixsum_monitor_chk #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned USER_W = 2,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              s_valid,
  input logic              s_ready,
  input logic [PIX_W-1:0]  s_data,
  input logic [USER_W-1:0] s_user,
  input logic              s_last,
  input logic              m_valid,
  input logic              m_ready,
  input logic [PIX_W-1:0]  m_data,
  input logic [USER_W-1:0] m_user,
  input logic              m_last,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wbit0,
  input logic              irq,
  input logic              frame_done
);
  logic clr_req;
  assign clr_req = reg_wr & (reg_addr == ADDR_W'(pixsum_pkg::SEL_STAT)) & wbit0;

  p_fwd_fields_r1: assert property (@(posedge clk) disable iff (rst)
    (m_valid == s_valid) && (m_data == s_data) && (m_user == s_user) && (m_last == s_last));

  p_ready_mirror_r2: assert property (@(posedge clk) disable iff (rst)
    s_ready == m_ready);

  p_done_from_eof_r3: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(s_valid && m_ready && s_user[pixsum_pkg::USER_EOF_BIT]));

  p_irq_set_r7: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> irq);

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_req) |=> irq);

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (irq && clr_req && !frame_done) |=> !irq);

  p_irq_rise_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(frame_done));
endmodule

bind pixsum_monitor pixsum_monitor_chk #(
  .PIX_W(PIX_W), .USER_W(USER_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .s_data(s_data), .s_user(s_user), .s_last(s_last),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_user(m_user), .m_last(m_last), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .wbit0(reg_wdata[0]), .irq(irq),
  .frame_done(frame_done)
);

// File: tb/test_pixsum_monitor.sv
`timescale 1ns/1ps
module test_pixsum_monitor;
  logic        clk = 1'b0;
  logic        rst;
  logic        s_valid, s_ready, s_last;
  logic [7:0]  s_data;
  logic [1:0]  s_user;
  logic        m_valid, m_ready, m_last;
  logic [7:0]  m_data;
  logic [1:0]  m_user;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;

  int nchk = 0;
  int nbad = 0;
  int pass_bad = 0;
  int rp = 0;

  always #2.5 clk = ~clk;

  pixsum_monitor i_pixsum_monitor (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_user(s_user), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_user(m_user), .m_last(m_last), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  // frame table: width, height, seed
  localparam logic [23:0] VEC [5] = '{
    {8'd4,  8'd3, 8'd1},
    {8'd1,  8'd1, 8'd7},
    {8'd9,  8'd2, 8'd200},
    {8'd16, 8'd6, 8'd3},
    {8'd1,  8'd5, 8'd9}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pv(input int seed, input int x, input int y);
    return 8'(seed * 13 + x * 7 + y * 29);
  endfunction

  task automatic send_beat(input logic [7:0] d, input bit sof, input bit eof, input bit eol);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_user = {eof, sof}; s_last = eol;
    forever begin
      m_ready = (rp % 3) != 2;
      rp++;
      #1;
      if (m_data !== s_data || m_user !== s_user || m_last !== s_last ||
          m_valid !== s_valid || s_ready !== m_ready) pass_bad++;
      @(posedge clk);
      if (m_ready) break;
      @(negedge clk);
    end
    #1 s_valid = 1'b0;
  endtask

  task automatic send_frame(input int w, input int h, input int seed, output int sum);
    sum = 0;
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        automatic logic [7:0] d = pv(seed, x, y);
        automatic bit lastb = (x == w - 1) && (y == h - 1);
        sum += int'(d);
        send_beat(d, (x == 0) && (y == 0), lastb, x == w - 1);
        if (!lastb && ((x + y) % 4 == 3)) @(negedge clk);
      end
    end
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int v, s, last_sum;
    rst = 1'b1; s_valid = 1'b0; s_data = '0; s_user = '0; s_last = 1'b0;
    m_ready = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10 reset state
    #1 chk(irq == 1'b0, "R10 irq after reset", int'(irq), 0);
    rd(4'd0, v); chk(v == 0, "R10 SUM after reset", v, 0);
    rd(4'd1, v); chk(v == 0, "R10 WIDTH after reset", v, 0);
    rd(4'd3, v); chk(v == 0, "R10 STATUS after reset", v, 0);

    // table of frames
    last_sum = 0;
    for (int i = 0; i < 5; i++) begin
      automatic int w  = int'(VEC[i][23:16]);
      automatic int h  = int'(VEC[i][15:8]);
      automatic int sd = int'(VEC[i][7:0]);
      send_frame(w, h, sd, s);
      chk(irq == 1'b0, "R7 irq low at closing edge", int'(irq), 0);
      @(posedge clk); #1;
      chk(irq == 1'b1, "R7 irq high one edge later", int'(irq), 1);
      rd(4'd0, v); chk(v == s, "R3 frame sum", v, s);
      rd(4'd1, v); chk(v == w, "R4 frame width", v, w);
      rd(4'd2, v); chk(v == h, "R5 frame height", v, h);
      rd(4'd3, v); chk(v == 1, "R11 status shows irq", v, 1);
      wr(4'd3, 32'hFFFF_FFFE); chk(irq == 1'b1, "R7 clear with bit0 low", int'(irq), 1);
      wr(4'd0, 32'h1);         chk(irq == 1'b1, "R7 write other address", int'(irq), 1);
      wr(4'd3, 32'h1);         chk(irq == 1'b0, "R7 clear with bit0 high", int'(irq), 0);
      last_sum = s;
    end
    chk(pass_bad == 0, "R1 R2 pass-through mismatches", pass_bad, 0);
    rd(4'd7, v); chk(v == 0, "R11 unmapped address", v, 0);

    // R9 beats outside a frame, including one with end-of-frame
    send_beat(8'd50, 1'b0, 1'b0, 1'b0);
    send_beat(8'd60, 1'b0, 1'b0, 1'b1);
    send_beat(8'd70, 1'b0, 1'b1, 1'b1);
    repeat (3) @(posedge clk); #1;
    chk(irq == 1'b0, "R9 no irq outside frame", int'(irq), 0);
    rd(4'd0, v); chk(v == last_sum, "R9 sum untouched outside frame", v, last_sum);

    // R6 partial frame keeps old results
    send_beat(8'd100, 1'b1, 1'b0, 1'b0);
    send_beat(8'd101, 1'b0, 1'b0, 1'b0);
    send_beat(8'd102, 1'b0, 1'b0, 1'b1);
    rd(4'd0, v); chk(v == last_sum, "R6 sum held during frame", v, last_sum);
    rd(4'd1, v); chk(v == 1, "R6 width held during frame", v, 1);

    // R12 restart inside the open frame
    send_beat(8'd10, 1'b1, 1'b0, 1'b0);
    send_beat(8'd20, 1'b0, 1'b0, 1'b0);
    send_beat(8'd30, 1'b0, 1'b1, 1'b1);
    repeat (2) @(posedge clk);
    rd(4'd0, v); chk(v == 60, "R12 restarted sum", v, 60);
    rd(4'd1, v); chk(v == 3, "R12 restarted width", v, 3);
    rd(4'd2, v); chk(v == 1, "R12 restarted height", v, 1);
    wr(4'd3, 32'h1);

    // R8 completion and clear collide
    wr(4'd3, 32'h1);
    send_beat(8'd5, 1'b1, 1'b0, 1'b0);
    send_beat(8'd6, 1'b0, 1'b1, 1'b1);
    wr(4'd3, 32'h1);
    chk(irq == 1'b1, "R8 irq kept on collision", int'(irq), 1);
    @(posedge clk); #1;
    chk(irq == 1'b1, "R8 irq still high after", int'(irq), 1);
    rd(4'd0, v); chk(v == 11, "R8 new sum after collision", v, 11);
    wr(4'd3, 32'h1); chk(irq == 1'b0, "R8 later clear works", int'(irq), 0);

    // R10 reset with results present
    send_frame(3, 2, 5, s);
    @(posedge clk);
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1 chk(irq == 1'b0, "R10 irq after mid-run reset", int'(irq), 0);
    rd(4'd0, v); chk(v == 0, "R10 sum after mid-run reset", v, 0);
    rd(4'd2, v); chk(v == 0, "R10 height after mid-run reset", v, 0);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule